// File: doc/BRIEF.md
# Data-Gated Command Presenter

This block sits between the parser of a serial link and an accelerator function unit (AFU). It queues the host-initiated commands that the parser decodes. It holds each command back from the AFU until every 64-byte data beat that belongs to that command has arrived on chip. Commands leave in arrival order, at most one per clock cycle, and only while the AFU holds an issue credit.

The parser supplies each command as a single-cycle record with these fields:

- opcode, tag, address
- a full-length code and a partial-length code
- a flag saying whether the command carries data
- a flag saying which of the two length codes applies

A separate strobe marks each data beat that arrives from the link. The block counts those beats against the command at the head of the queue.

The AFU returns credits one pulse at a time. A command with a reserved length code does not wait for data. It is handed out at once with an error flag.

Top module: `cmd_data_gate`

## Requirements
- R1: A command with `cmd_has_data_i`=0 becomes visible on `out_valid_o` in the cycle after it is accepted, provided it is at the head of the queue and a credit is held.
- R2: A data-carrying command with `cmd_partial_i`=0 needs 1, 2 or 4 beats for `cmd_dlen_i` codes 01, 10 and 11 (64, 128 and 256 bytes). It is not presented until that many beats have been counted on `beat_i`. Beats that arrive before their command still count toward it.
- R3: A data-carrying command with `cmd_partial_i`=1 and `cmd_plen_i` from 000 to 101 (1 to 32 bytes) needs exactly one beat.
- R4: A data-carrying command with a reserved length code is presented without waiting for data, with `out_err_o`=1, and consumes no beats. The reserved codes are `cmd_dlen_i`=00 when `cmd_partial_i`=0, and `cmd_plen_i`=110 or 111 when `cmd_partial_i`=1.
- R5: Commands are presented strictly in arrival order. A head command that is still waiting for data blocks every command behind it.
- R6: At most one command is presented per cycle. Opcode, tag, address and length codes on the output equal the values that were accepted with that command.
- R7: A command is presented only while at least one credit is held. Each presented command consumes one credit.
- R8: After reset the credit count is `MAX_CREDITS`. Each `credit_ret_i` pulse adds one credit. The count saturates at `MAX_CREDITS`.
- R9: During and right after reset, `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | A command record is present this cycle |
| cmd_opcode_i | input | 8 | Command opcode |
| cmd_tag_i | input | 16 | Host command tag |
| cmd_addr_i | input | 64 | Physical address |
| cmd_dlen_i | input | 2 | Full data-length code |
| cmd_plen_i | input | 3 | Partial-length code |
| cmd_has_data_i | input | 1 | The command carries payload from the link |
| cmd_partial_i | input | 1 | The partial-length code applies instead of the full-length code |
| beat_i | input | 1 | One 64-byte data beat has arrived |
| credit_ret_i | input | 1 | The AFU returns one credit |
| out_valid_o | output | 1 | A command is presented this cycle |
| out_opcode_o | output | 8 | Presented opcode |
| out_tag_o | output | 16 | Presented tag |
| out_addr_o | output | 64 | Presented address |
| out_dlen_o | output | 2 | Presented full-length code |
| out_plen_o | output | 3 | Presented partial-length code |
| out_err_o | output | 1 | The presented command had a reserved length code |

## Verification
The bench builds the block with a queue depth of 4 and `MAX_CREDITS`=2.

The small credit limit lets a burst of three commands with no data run the pool dry in a few cycles. That exposes the credit stall and its release. Surplus credit-return pulses then show the ceiling: exactly two commands go out before the next stall.

A depth of 4 is enough to place a data-less command behind a head that is waiting for its beat. That checks the ordering rule without filling the queue.

// File: rtl/cmd_gate_pkg.sv
package cmd_gate_pkg;
  localparam int OPC_W  = 8;
  localparam int TAG_W  = 16;
  localparam int ADDR_W = 64;
  localparam int BEAT_W = 3;

  typedef struct packed {
    logic [OPC_W-1:0]  opcode;
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        dlen;
    logic [2:0]        plen;
    logic              err;
    logic [BEAT_W-1:0] beats;
  } cmd_entry_t;

  function automatic logic len_reserved(logic has_data, logic partial,
                                        logic [1:0] dlen, logic [2:0] plen);
    if (!has_data) return 1'b0;
    if (partial)   return plen[2] & plen[1];
    return dlen == 2'b00;
  endfunction

  // 64-byte beats: partial -> 1, full 01/10/11 -> 1/2/4
  function automatic logic [BEAT_W-1:0] beats_needed(logic has_data, logic partial,
                                                     logic [1:0] dlen, logic [2:0] plen);
    if (!has_data || len_reserved(has_data, partial, dlen, plen)) return '0;
    if (partial) return BEAT_W'(1);
    case (dlen)
      2'b01:   return BEAT_W'(1);
      2'b10:   return BEAT_W'(2);
      default: return BEAT_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/cg_fifo.sv
module cg_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign head_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= inc(wr_q);
      if (pop_i)  rd_q <= inc(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !pop_i |-> !push_i);  // R5
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);  // R6
endmodule

// File: rtl/cg_beat_acc.sv
module cg_beat_acc #(
  parameter int CNT_W  = 6,
  parameter int BEAT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_i,
  input  logic              take_i,
  input  logic [BEAT_W-1:0] take_n_i,
  output logic [CNT_W-1:0]  avail_o
);
  logic [CNT_W-1:0] cnt_q;
  assign avail_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else cnt_q <= cnt_q + CNT_W'(beat_i) - (take_i ? CNT_W'(take_n_i) : '0);
  end

  AST_BEATS_COVER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> cnt_q >= CNT_W'(take_n_i));  // R2
  AST_BEAT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && !take_i |-> cnt_q != '1);  // R2
endmodule

// File: rtl/cg_credit.sv
module cg_credit #(
  parameter int MAX_CREDITS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic ret_i,
  output logic has_o
);
  localparam int CRD_W = $clog2(MAX_CREDITS + 1) + 1;

  logic [CRD_W-1:0] crd_q, crd_sum;

  assign has_o   = (crd_q != '0);
  assign crd_sum = crd_q + CRD_W'(ret_i) - CRD_W'(take_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crd_q <= CRD_W'(MAX_CREDITS);
    else crd_q <= (crd_sum > CRD_W'(MAX_CREDITS)) ? CRD_W'(MAX_CREDITS) : crd_sum;
  end

  AST_CREDIT_CEILING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crd_q <= CRD_W'(MAX_CREDITS));  // R8
  AST_TAKE_NEEDS_CREDIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> crd_q != '0);  // R7
  AST_TAKE_DECREMENTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !ret_i |=> crd_q == $past(crd_q) - CRD_W'(1));  // R7
endmodule

// File: rtl/cmd_data_gate.sv
module cmd_data_gate
  import cmd_gate_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int MAX_CREDITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [OPC_W-1:0]  cmd_opcode_i,
  input  logic [TAG_W-1:0]  cmd_tag_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [1:0]        cmd_dlen_i,
  input  logic [2:0]        cmd_plen_i,
  input  logic              cmd_has_data_i,
  input  logic              cmd_partial_i,
  input  logic              beat_i,
  input  logic              credit_ret_i,
  output logic              out_valid_o,
  output logic [OPC_W-1:0]  out_opcode_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [1:0]        out_dlen_o,
  output logic [2:0]        out_plen_o,
  output logic              out_err_o
);
  localparam int ENTRY_W = $bits(cmd_entry_t);
  localparam int BCNT_W  = $clog2(DEPTH * 4 + 1) + 2;

  cmd_entry_t in_ent, head_ent;
  logic [ENTRY_W-1:0] head_raw;
  logic empty, full, has_credit, release_c;
  logic [BCNT_W-1:0] avail;

  always_comb begin
    in_ent.opcode = cmd_opcode_i;
    in_ent.tag    = cmd_tag_i;
    in_ent.addr   = cmd_addr_i;
    in_ent.dlen   = cmd_dlen_i;
    in_ent.plen   = cmd_plen_i;
    in_ent.err    = len_reserved(cmd_has_data_i, cmd_partial_i, cmd_dlen_i, cmd_plen_i);
    in_ent.beats  = beats_needed(cmd_has_data_i, cmd_partial_i, cmd_dlen_i, cmd_plen_i);
  end

  cg_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .push_i (cmd_valid_i),
    .data_i (in_ent),
    .pop_i  (release_c),
    .head_o (head_raw),
    .empty_o(empty),
    .full_o (full)
  );

  assign head_ent = cmd_entry_t'(head_raw);

  cg_beat_acc #(.CNT_W(BCNT_W), .BEAT_W(BEAT_W)) u_beats (
    .clk_i, .rst_ni,
    .beat_i,
    .take_i  (release_c),
    .take_n_i(head_ent.beats),
    .avail_o (avail)
  );

  cg_credit #(.MAX_CREDITS(MAX_CREDITS)) u_credit (
    .clk_i, .rst_ni,
    .take_i(release_c),
    .ret_i (credit_ret_i),
    .has_o (has_credit)
  );

  assign release_c    = !empty && has_credit && (avail >= BCNT_W'(head_ent.beats));
  assign out_valid_o  = release_c;
  assign out_opcode_o = head_ent.opcode;
  assign out_tag_o    = head_ent.tag;
  assign out_addr_o   = head_ent.addr;
  assign out_dlen_o   = head_ent.dlen;
  assign out_plen_o   = head_ent.plen;
  assign out_err_o    = release_c && head_ent.err;

  AST_HEAD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty && !out_valid_o |=> $stable(out_tag_o) && $stable(out_addr_o));  // R5
  AST_ERR_ONLY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_err_o |-> out_valid_o);  // R4
  AST_IN_NOT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> !full || out_valid_o);  // R6
endmodule

// File: tb/cmd_data_gate_test.sv
module cmd_data_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cmd_valid = 0, has_data = 0, partial = 0, beat = 0, cret = 0;
  logic [7:0]  opc = '0;
  logic [15:0] tag = '0;
  logic [63:0] addr = '0;
  logic [1:0]  dlen = '0;
  logic [2:0]  plen = '0;
  logic        o_valid, o_err;
  logic [7:0]  o_opc;
  logic [15:0] o_tag;
  logic [63:0] o_addr;
  logic [1:0]  o_dlen;
  logic [2:0]  o_plen;

  int checks = 0, errors = 0;
  bit done = 0;

  cmd_data_gate #(.DEPTH(4), .MAX_CREDITS(2)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_opcode_i(opc), .cmd_tag_i(tag), .cmd_addr_i(addr),
    .cmd_dlen_i(dlen), .cmd_plen_i(plen), .cmd_has_data_i(has_data), .cmd_partial_i(partial),
    .beat_i(beat), .credit_ret_i(cret),
    .out_valid_o(o_valid), .out_opcode_o(o_opc), .out_tag_o(o_tag), .out_addr_o(o_addr),
    .out_dlen_o(o_dlen), .out_plen_o(o_plen), .out_err_o(o_err)
  );

  task automatic push(input logic [15:0] t, input logic hd, input logic pt,
                      input logic [1:0] dl, input logic [2:0] pl);
    cmd_valid = 1; tag = t; opc = t[7:0] + 8'd1; addr = {t, ~t, t, 16'h0C0D};
    has_data = hd; partial = pt; dlen = dl; plen = pl;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic give_beat();
    beat = 1; @(negedge clk); beat = 0;
  endtask

  task automatic ret();
    cret = 1; @(negedge clk); cret = 0;
  endtask

  task automatic chk(input logic v, input logic [15:0] t, input logic e, input string req);
    checks++;
    if (o_valid !== v) begin
      errors++;
      $display("FAIL %s: valid=%b expected %b", req, o_valid, v);
    end else if (v && (o_tag !== t || o_err !== e || o_opc !== t[7:0] + 8'd1 ||
                       o_addr !== {t, ~t, t, 16'h0C0D})) begin
      errors++;
      $display("FAIL %s: tag=%h err=%b opc=%h addr=%h expected tag=%h err=%b",
               req, o_tag, o_err, o_opc, o_addr, t, e);
    end
  endtask

  task automatic t_reset();
    chk(0, 0, 0, "R9 reset");
    rst_n = 1;
    @(negedge clk);
    chk(0, 0, 0, "R9 after reset");
  endtask

  task automatic t_no_data();
    push(16'h0011, 0, 0, 2'b00, 3'b000);
    chk(1, 16'h0011, 0, "R1 no-data immediate");
    checks++;
    if (o_dlen !== 2'b00 || o_plen !== 3'b000) begin
      errors++; $display("FAIL R6: dlen=%b plen=%b expected 00 000", o_dlen, o_plen);
    end
    ret();
    chk(0, 0, 0, "R6 single presentation");
  endtask

  task automatic t_full();
    push(16'h0022, 1, 0, 2'b10, 3'b000);
    chk(0, 0, 0, "R2 128B waits");
    give_beat();
    chk(0, 0, 0, "R2 128B one beat");
    give_beat();
    chk(1, 16'h0022, 0, "R2 128B complete");
    checks++;
    if (o_dlen !== 2'b10) begin
      errors++; $display("FAIL R6: dlen=%b expected 10", o_dlen);
    end
    ret();
    push(16'h0023, 1, 0, 2'b11, 3'b000);
    for (int i = 0; i < 3; i++) give_beat();
    chk(0, 0, 0, "R2 256B three beats");
    give_beat();
    chk(1, 16'h0023, 0, "R2 256B complete");
    ret();
    give_beat();
    push(16'h0024, 1, 0, 2'b01, 3'b000);
    chk(1, 16'h0024, 0, "R2 early beat counts");
    ret();
  endtask

  task automatic t_partial();
    push(16'h0031, 1, 1, 2'b11, 3'b101);
    chk(0, 0, 0, "R3 partial waits");
    give_beat();
    chk(1, 16'h0031, 0, "R3 32B one beat");
    ret();
    push(16'h0032, 1, 1, 2'b00, 3'b000);
    give_beat();
    chk(1, 16'h0032, 0, "R3 1B one beat");
    ret();
  endtask

  task automatic t_reserved();
    push(16'h0041, 1, 0, 2'b00, 3'b000);
    chk(1, 16'h0041, 1, "R4 dlen 00 flagged");
    ret();
    push(16'h0042, 1, 1, 2'b11, 3'b111);
    chk(1, 16'h0042, 1, "R4 plen 111 flagged");
    ret();
    push(16'h0043, 1, 1, 2'b01, 3'b110);
    chk(1, 16'h0043, 1, "R4 plen 110 flagged");
    ret();
    push(16'h0044, 1, 0, 2'b01, 3'b000);
    chk(0, 0, 0, "R4 no beats consumed or banked");
    give_beat();
    chk(1, 16'h0044, 0, "R4 following cmd");
    ret();
  endtask

  task automatic t_order();
    push(16'h0051, 1, 0, 2'b01, 3'b000);
    push(16'h0052, 0, 0, 2'b00, 3'b000);
    chk(0, 0, 0, "R5 blocked behind head");
    give_beat();
    chk(1, 16'h0051, 0, "R5 head first");
    ret();
    chk(1, 16'h0052, 0, "R5 then follower");
    ret();
    chk(0, 0, 0, "R5 queue drained");
  endtask

  task automatic t_credit();
    push(16'h0061, 0, 0, 2'b00, 3'b000);
    chk(1, 16'h0061, 0, "R7 credit 2");
    push(16'h0062, 0, 0, 2'b00, 3'b000);
    chk(1, 16'h0062, 0, "R7 credit 1");
    push(16'h0063, 0, 0, 2'b00, 3'b000);
    chk(0, 0, 0, "R7 out of credit");
    ret();
    chk(1, 16'h0063, 0, "R8 return unblocks");
    ret();
    for (int i = 0; i < 5; i++) ret();
    push(16'h0071, 0, 0, 2'b00, 3'b000);
    push(16'h0072, 0, 0, 2'b00, 3'b000);
    push(16'h0073, 0, 0, 2'b00, 3'b000);
    chk(0, 0, 0, "R8 saturated at max");
    ret();
    chk(1, 16'h0073, 0, "R8 resume");
    ret();
    ret();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_no_data();
    t_full();
    t_partial();
    t_reserved();
    t_order();
    t_credit();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule